// File: doc/BRIEF.md
# Reply timeout encoder

This block turns a requested reply timeout, given in microseconds, into the two fields of a receiver timeout register: a 2-bit multiplier code that picks the time unit and a 7-bit length that counts those units. Small requests are encoded with a fine 8 µs unit. Larger ones move to coarser units of 16, 32 or 64 µs, so the 7-bit length still covers the request. The length is rounded up, so the programmed timeout is never shorter than the request. It is clamped at the largest value the field can hold.

Each write also reports the timeout that was in effect before the update. This value is decoded from the old register contents as the old length times the unit that the old code selected. Software can save it and restore it later. A zero request programs a fixed default setting.

Top module: `reply_timeout_enc`

## Requirements
- R1: After reset the multiplier code is 0, the length field is 69 and the previous-timeout output is 0.
- R2: A write with a request of 0 loads multiplier code 0 and length 69.
- R3: A write with a request from 1 to 1016 loads code 0, and the length is the request divided by 8, rounded up.
- R4: A write with a request from 1017 to 2032 loads code 1 (unit 16 µs). A request from 2033 to 4064 loads code 2 (unit 32 µs). In both cases the length is the request divided by the unit, rounded up.
- R5: A write with a request above 4064 loads code 3 (unit 64 µs), and the rounded-up quotient is clamped to 127.
- R6: Rounding up applies only when the division leaves a remainder. An exact multiple of the unit gives the plain quotient.
- R7: On each write, the previous-timeout output is loaded, in the same clock edge, with the old length shifted left by 3 plus the old code. This equals the old length times 8, 16, 32 or 64.
- R8: In cycles without a write, the code, the length and the previous-timeout output all keep their values.
- R9: Any 32-bit request, up to 0xFFFFFFFF, encodes without wrap-around: code 3 and length 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe: encode reqUs at this edge |
| reqUs | input | 32 | Requested reply timeout in microseconds |
| mulCode | output | 2 | Stored multiplier code (0..3 select 8/16/32/64 µs) |
| lenField | output | 7 | Stored length field in units of the selected unit |
| prevUs | output | 32 | Timeout in µs held by the fields before the last write |

## Verification
The bench builds the block with its default parameters: a 32-bit request, a 7-bit length, an 8 µs base unit and a 2-bit code. With these values every range edge is a small integer that the bench can reach directly: 1016/1017, 2032/2033 and 4064/4065. The saturation edge at 8128/8129 and the full-scale request 0xFFFFFFFF are also in reach. Back-to-back writes chain each expected previous timeout to the setting made just before it, so the decode is exercised for all four codes.

// File: rtl/rto_pkg.sv
package rto_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capturePrev;
    logic loadFields;
  } rtoStrobeT;
endpackage

// File: rtl/rto_encode.sv
module rto_encode #(
  parameter int REQ_W     = 32,
  parameter int LEN_W     = 7,
  parameter int MULT_W    = 2,
  parameter int BASE_LOG2 = 3,
  parameter int DEF_LEN   = 69
) (
  input  logic [REQ_W-1:0]  reqUs,
  output logic [MULT_W-1:0] mulNext,
  output logic [LEN_W-1:0]  lenNext
);
  localparam int NUM_RANGES = 1 << MULT_W;
  localparam int LEN_MAX    = (1 << LEN_W) - 1;
  localparam longint STEP   = longint'(LEN_MAX) << BASE_LOG2;

  logic [NUM_RANGES-1:0] fits;
  logic [LEN_W-1:0]      satLen [NUM_RANGES];

  // One ceiling divider per unit; each is a shift plus a sticky remainder bit
  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_unit
    localparam int SHIFT = BASE_LOG2 + g;
    localparam logic [REQ_W-1:0] REM_MASK = REQ_W'((64'd1 << SHIFT) - 64'd1);
    localparam logic [REQ_W:0]   LIMIT    = (REQ_W+1)'(STEP << g);
    logic [REQ_W-1:0] quot;
    logic [REQ_W:0]   ceilQ;
    assign quot  = reqUs >> SHIFT;
    assign ceilQ = {1'b0, quot} + (REQ_W+1)'(|(reqUs & REM_MASK));
    assign satLen[g] = (ceilQ > (REQ_W+1)'(LEN_MAX)) ? LEN_W'(LEN_MAX) : ceilQ[LEN_W-1:0];
    if (g == NUM_RANGES - 1) begin : g_last
      assign fits[g] = 1'b1;
    end else begin : g_mid
      assign fits[g] = ({1'b0, reqUs} <= LIMIT);
    end
  end

  // The finest unit that covers the request wins
  always_comb begin
    mulNext = MULT_W'(NUM_RANGES - 1);
    lenNext = satLen[NUM_RANGES-1];
    for (int i = NUM_RANGES - 2; i >= 0; i--) begin
      if (fits[i]) begin
        mulNext = MULT_W'(i);
        lenNext = satLen[i];
      end
    end
    if (reqUs == '0) begin
      mulNext = '0;
      lenNext = LEN_W'(DEF_LEN);
    end
  end
endmodule

// File: rtl/rto_ctrl.sv
module rto_ctrl
  import rto_pkg::*;
(
  input  logic      wrEn,
  output rtoStrobeT strobes
);
  // A write captures the old value and loads the new fields on one edge
  always_comb begin
    strobes.capturePrev = wrEn;
    strobes.loadFields  = wrEn;
  end
endmodule

// File: rtl/rto_datapath.sv
module rto_datapath
  import rto_pkg::*;
#(
  parameter int REQ_W     = 32,
  parameter int LEN_W     = 7,
  parameter int MULT_W    = 2,
  parameter int BASE_LOG2 = 3,
  parameter int DEF_LEN   = 69
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtoStrobeT         strobes,
  input  logic [MULT_W-1:0] mulNext,
  input  logic [LEN_W-1:0]  lenNext,
  output logic [MULT_W-1:0] mulCode,
  output logic [LEN_W-1:0]  lenField,
  output logic [REQ_W-1:0]  prevUs
);
  logic [REQ_W-1:0] oldDecoded;

  // Old length times the unit picked by the old code
  assign oldDecoded = REQ_W'(lenField) << (BASE_LOG2 + int'(mulCode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulCode  <= '0;
      lenField <= LEN_W'(DEF_LEN);
    end else if (strobes.loadFields) begin
      mulCode  <= mulNext;
      lenField <= lenNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevUs <= '0;
    end else if (strobes.capturePrev) begin
      prevUs <= oldDecoded;
    end
  end

  // R7: previous value reflects the fields seen one cycle earlier
  p_prev_decode_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capturePrev |=> prevUs == (REQ_W'($past(lenField)) << (BASE_LOG2 + int'($past(mulCode)))));

  // R8: nothing moves without a write
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadFields && !strobes.capturePrev |=>
      $stable(mulCode) && $stable(lenField) && $stable(prevUs));
endmodule

// File: rtl/reply_timeout_enc.sv
module reply_timeout_enc
  import rto_pkg::*;
#(
  parameter int REQ_W     = 32,
  parameter int LEN_W     = 7,
  parameter int MULT_W    = 2,
  parameter int BASE_LOG2 = 3,
  parameter int DEF_LEN   = 69
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REQ_W-1:0]  reqUs,
  output logic [MULT_W-1:0] mulCode,
  output logic [LEN_W-1:0]  lenField,
  output logic [REQ_W-1:0]  prevUs
);
  localparam int LEN_MAX = (1 << LEN_W) - 1;
  localparam int NUM_RANGES = 1 << MULT_W;
  localparam logic [REQ_W-1:0] STEP = REQ_W'(longint'(LEN_MAX) << BASE_LOG2);
  localparam logic [REQ_W-1:0] TOP_EDGE = REQ_W'(longint'(LEN_MAX) << (BASE_LOG2 + NUM_RANGES - 2));

  rtoStrobeT         strobes;
  logic [MULT_W-1:0] mulNext;
  logic [LEN_W-1:0]  lenNext;

  rto_ctrl u_ctrl (.wrEn(wrEn), .strobes(strobes));

  rto_encode #(.REQ_W(REQ_W), .LEN_W(LEN_W), .MULT_W(MULT_W),
               .BASE_LOG2(BASE_LOG2), .DEF_LEN(DEF_LEN)) u_enc (
    .reqUs(reqUs), .mulNext(mulNext), .lenNext(lenNext));

  rto_datapath #(.REQ_W(REQ_W), .LEN_W(LEN_W), .MULT_W(MULT_W),
                 .BASE_LOG2(BASE_LOG2), .DEF_LEN(DEF_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .mulNext(mulNext), .lenNext(lenNext),
    .mulCode(mulCode), .lenField(lenField), .prevUs(prevUs));

  // R2: zero request loads the default setting
  p_zero_default_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && reqUs == '0 |=> mulCode == '0 && lenField == LEN_W'(DEF_LEN));

  // R3: finest range, ceiling quotient of the base unit
  p_first_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && reqUs != '0 && reqUs <= STEP |=> mulCode == '0 &&
      lenField == LEN_W'(($past(reqUs) + REQ_W'((1 << BASE_LOG2) - 1)) >> BASE_LOG2));

  // R5: above the top edge the coarsest code is used
  p_top_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && reqUs > TOP_EDGE |=> mulCode == MULT_W'(NUM_RANGES - 1));

  // R9: the largest request saturates the length instead of wrapping
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && reqUs == '1 |=> lenField == LEN_W'(LEN_MAX));
endmodule

// File: tb/reply_timeout_enc_bench.sv
module reply_timeout_enc_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN  = 1'b0;
  logic        wrEn  = 1'b0;
  logic [31:0] reqUs = '0;
  logic [1:0]  mulCode;
  logic [6:0]  lenField;
  logic [31:0] prevUs;

  reply_timeout_enc u_reply_timeout_enc (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .reqUs(reqUs),
    .mulCode(mulCode), .lenField(lenField), .prevUs(prevUs));

  typedef struct {
    logic [31:0] req;
    longint      expMul;
    longint      expLen;
    longint      expPrev;
    string       tag;
  } expItemT;

  expItemT sbQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;
  longint modelMul = 0;
  longint modelLen = 69;
  longint modelPrev = 0;

  task automatic checkEq(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Encoding written from the requirements
  task automatic model(input logic [31:0] r, output longint m, output longint l);
    longint rq;
    int k;
    rq = longint'(r);
    if (rq == 0) begin m = 0; l = 69; return; end
    if (rq <= 1016)      begin k = 3; m = 0; end
    else if (rq <= 2032) begin k = 4; m = 1; end
    else if (rq <= 4064) begin k = 5; m = 2; end
    else                 begin k = 6; m = 3; end
    l = rq >> k;
    if ((rq & ((longint'(1) << k) - 1)) != 0) l = l + 1;
    if (l > 127) l = 127;
  endtask

  task automatic drive(input logic [31:0] r, input string tag);
    expItemT it;
    longint m, l;
    model(r, m, l);
    it.req = r; it.expMul = m; it.expLen = l; it.tag = tag;
    it.expPrev = modelLen << (3 + modelMul);
    sbQ.push_back(it);
    modelMul = m; modelLen = l; modelPrev = it.expPrev;
    @(negedge clk);
    wrEn = 1'b1;
    reqUs = r;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Monitor: a write seen at an edge is compared half a cycle later
  initial begin
    forever begin
      @(posedge clk);
      if (wrEn && rstN) begin
        @(negedge clk);
        if (sbQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL R7 unexpected write actual=1 expected=0");
        end else begin
          expItemT it;
          it = sbQ.pop_front();
          checkEq(it.tag, "mulCode", longint'(mulCode), it.expMul);
          checkEq(it.tag, "lenField", longint'(lenField), it.expLen);
          checkEq("R7", "prevUs", longint'(prevUs), it.expPrev);
        end
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R1", "mulCode", longint'(mulCode), 0);
    checkEq("R1", "lenField", longint'(lenField), 69);
    checkEq("R1", "prevUs", longint'(prevUs), 0);
    rstN = 1'b1;
    @(negedge clk);

    drive(32'd0, "R2");
    drive(32'd1, "R3");
    drive(32'd9, "R6");
    drive(32'd64, "R6");
    drive(32'd1016, "R3");
    drive(32'd1017, "R4");
    drive(32'd2032, "R4");
    drive(32'd2033, "R4");
    drive(32'd4064, "R4");
    drive(32'd4065, "R5");
    drive(32'd8128, "R5");
    drive(32'd8129, "R5");
    drive(32'hFFFF_FFFF, "R9");
    drive(32'd100, "R3");

    // R8: idle cycles with a changing request leave everything alone
    reqUs = 32'd5000;
    repeat (6) @(negedge clk);
    checkEq("R8", "mulCode", longint'(mulCode), modelMul);
    checkEq("R8", "lenField", longint'(lenField), modelLen);
    checkEq("R8", "prevUs", longint'(prevUs), modelPrev);

    drive(32'd0, "R2");
    repeat (3) @(negedge clk);
    checkEq("R7", "queue drained", longint'(sbQ.size()), 0);
    finish();
  end
endmodule